// File: doc/BRIEF.md
# Cycle-Skipping On/Off Gate Controller

This block decides, one oscillator cycle at a time, whether the gate of a power switch is driven. An oscillator supplies a cycle-start strobe and a maximum-duty window. At each cycle-start strobe the block looks at a digitized feedback comparator. If feedback asks for energy, the gate turns on for that cycle. If it does not, the whole cycle is skipped. Regulation therefore comes from how many cycles are skipped, not from the width of each pulse. Once a cycle has begun, later changes on the feedback input do not alter the decision for that cycle.

A cycle that was switched on can end early for three reasons:

- the switch-current comparator trips after a leading-edge blanking interval;
- the duty window closes;
- a protection lock engages.

There are three locks, and each is a set/clear latch with its own release flag, which gives hysteresis:

- Supply undervoltage sets its lock, and a supply-good flag releases it.
- Over-temperature sets its lock, and a cooled-down flag releases it.
- An overcurrent on the feedback input, seen while the switch is on in consecutive cycles, trips a fault lock. That lock raises a restart request towards an external auto-restart timer, and the timer releases it with a clear pulse.

Top module: `onoff_gate_ctrl`

## Requirements
- R1: When `cyc_start` is high at a clock edge, `fb_above` is high, `duty_win` is high and no lock is engaged (or being engaged) at that edge, `gate_on` is high in the cycle after that edge.
- R2: `gate_on` can rise only at an edge where `cyc_start` is high. If `fb_above` is low at the cycle-start edge, `gate_on` stays low until the next cycle-start edge, whatever `fb_above` does in between.
- R3: With blanking over, `ilim` high at an edge while `gate_on` is high drives `gate_on` low in the next cycle. It then stays low until the next cycle-start edge.
- R4: `ilim` is ignored at the BLANK clock edges that follow the edge which turned the gate on (parameter BLANK, default 8).
- R5: `duty_win` low at an edge without `cyc_start` forces `gate_on` low in the next cycle. A cycle-start edge with `duty_win` low does not turn the gate on.
- R6: A fault trips in the following case. In SD_CYCLES consecutive switching cycles (default 2), `fb_sd` was high at some edge while `gate_on` was high. Then, at the cycle-start edge that closes the last of those cycles, the gate stays off and `restart_req` goes high in the next cycle. A cycle with no such event resets the count. `restart_req` stays high and the gate stays off until an `ar_clear` pulse.
- R7: `uv_low` forces `gate_on` low in the next cycle and holds switching off until `uv_good` is high while `uv_low` is low. After reset this lock is engaged. If both flags are high together, `uv_low` wins.
- R8: `ot_hot` forces `gate_on` low in the next cycle and holds switching off until `ot_cool` is high while `ot_hot` is low. After reset this lock is released. A release at a cycle-start edge allows that cycle to switch on.
- R9: Synchronous reset drives `gate_on` and `restart_req` low and clears the consecutive-fault count and the pending fault event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | One-clock strobe marking the start of an oscillator cycle |
| duty_win | input | 1 | High while the maximum-duty window is open |
| fb_above | input | 1 | Feedback comparator: high requests switching this cycle |
| fb_sd | input | 1 | Feedback overcurrent (line overvoltage) comparator |
| ilim | input | 1 | Switch current-limit comparator |
| uv_low | input | 1 | Supply below lower threshold |
| uv_good | input | 1 | Supply above upper threshold |
| ot_hot | input | 1 | Die above shutdown temperature |
| ot_cool | input | 1 | Die cooled below release temperature |
| ar_clear | input | 1 | Pulse from the auto-restart timer ending the off-time |
| gate_on | output | 1 | Registered power switch gate enable |
| restart_req | output | 1 | Registered auto-restart request, held until cleared |

## Verification
Every result is due in the cycle after the clock edge that samples its stimulus. This holds for the turn-on decision, current-limit and duty cut-off, lock entry and release, and the restart request. The bench therefore applies each stimulus at a falling edge and compares the outputs at the next falling edge, one register stage later.

The current-limit input is held high from the turn-on edge onwards, and the gate is expected to stay high for exactly BLANK further edges. The fault request is expected at the cycle-start edge that closes the second qualifying cycle, not earlier.

// File: rtl/onoff_pkg.sv
package onoff_pkg;
  localparam int NLOCK = 3;
  localparam int LK_UV = 0;
  localparam int LK_OT = 1;
  localparam int LK_AR = 2;
  // undervoltage lock is engaged out of reset, others released
  localparam logic [NLOCK-1:0] LOCK_RST = 3'b001;

  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/onoff_lock_latch.sv
module onoff_lock_latch #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o,
  output logic q_next_o
);
  logic q_r;

  // set dominates the release flag
  always_comb begin
    if (set_i)      q_next_o = 1'b1;
    else if (clr_i) q_next_o = 1'b0;
    else            q_next_o = q_r;
  end

  always_ff @(posedge clk) begin
    if (rst) q_r <= RST_VAL;
    else     q_r <= q_next_o;
  end

  assign q_o = q_r;

  // R6 R7 R8: an engage request always leaves the lock engaged
  assert_lock_set_R7: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q_o);
  // R7 R8: release without a concurrent set frees the lock
  assert_lock_clr_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/onoff_blanker.sv
module onoff_blanker #(
  parameter int BLANK = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic blank_o
);
  localparam int CW = onoff_pkg::cnt_width(BLANK);
  logic [CW-1:0] cnt_r;

  always_ff @(posedge clk) begin
    if (rst)               cnt_r <= '0;
    else if (load_i)       cnt_r <= CW'(BLANK);
    else if (cnt_r != '0)  cnt_r <= cnt_r - CW'(1);
  end

  assign blank_o = (cnt_r != '0);

  // R4: the edge after a turn-on starts inside the blanking window
  assert_blank_start_R4: assert property (@(posedge clk) disable iff (rst)
    load_i |=> blank_o);
endmodule

// File: rtl/onoff_sd_detect.sv
module onoff_sd_detect #(
  parameter int SD_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cyc_start_i,
  input  logic gate_i,
  input  logic fb_sd_i,
  input  logic clear_i,
  output logic trip_o
);
  localparam int CW = onoff_pkg::cnt_width(SD_CYCLES);
  logic [CW-1:0] cnt_r;
  logic          seen_r;
  logic          seen_now;

  assign seen_now = seen_r | (gate_i & fb_sd_i);
  assign trip_o   = cyc_start_i & seen_now & ((int'(cnt_r) + 1) >= SD_CYCLES);

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cnt_r  <= '0;
      seen_r <= 1'b0;
    end else if (cyc_start_i) begin
      seen_r <= 1'b0;
      if (!seen_now || trip_o) cnt_r <= '0;
      else                     cnt_r <= cnt_r + CW'(1);
    end else if (seen_now) begin
      seen_r <= 1'b1;
    end
  end

  // R6: a cycle closing with no shutdown event cannot trip
  assert_no_trip_clean_R6: assert property (@(posedge clk) disable iff (rst)
    (cyc_start_i && !seen_r && !(gate_i && fb_sd_i)) |-> !trip_o);
endmodule

// File: rtl/onoff_gate_ctrl.sv
module onoff_gate_ctrl #(
  parameter int BLANK     = 8,
  parameter int SD_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cyc_start,
  input  logic duty_win,
  input  logic fb_above,
  input  logic fb_sd,
  input  logic ilim,
  input  logic uv_low,
  input  logic uv_good,
  input  logic ot_hot,
  input  logic ot_cool,
  input  logic ar_clear,
  output logic gate_on,
  output logic restart_req
);
  import onoff_pkg::*;

  logic [NLOCK-1:0] lk_set, lk_clr, lk_q, lk_next;
  logic trip, blanking, allow_n, turn_on, gate_q, gate_d;

  assign lk_set[LK_UV] = uv_low;
  assign lk_clr[LK_UV] = uv_good;
  assign lk_set[LK_OT] = ot_hot;
  assign lk_clr[LK_OT] = ot_cool;
  assign lk_set[LK_AR] = trip;
  assign lk_clr[LK_AR] = ar_clear;

  for (genvar i = 0; i < NLOCK; i++) begin : g_lock
    onoff_lock_latch #(.RST_VAL(LOCK_RST[i])) u_lock (
      .clk      (clk),
      .rst      (rst),
      .set_i    (lk_set[i]),
      .clr_i    (lk_clr[i]),
      .q_o      (lk_q[i]),
      .q_next_o (lk_next[i])
    );
  end

  // look-ahead: locks engaging at this edge already block the gate
  assign allow_n = ~|lk_next;
  assign turn_on = cyc_start & fb_above & duty_win & allow_n;

  onoff_blanker #(.BLANK(BLANK)) u_blank (
    .clk     (clk),
    .rst     (rst),
    .load_i  (turn_on),
    .blank_o (blanking)
  );

  onoff_sd_detect #(.SD_CYCLES(SD_CYCLES)) u_sd (
    .clk         (clk),
    .rst         (rst),
    .cyc_start_i (cyc_start),
    .gate_i      (gate_q),
    .fb_sd_i     (fb_sd),
    .clear_i     (ar_clear),
    .trip_o      (trip)
  );

  always_comb begin
    if (!allow_n)                      gate_d = 1'b0;
    else if (cyc_start)                gate_d = turn_on;
    else if (!duty_win)                gate_d = 1'b0;
    else if (gate_q && ilim && !blanking) gate_d = 1'b0;
    else                               gate_d = gate_q;
  end

  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= gate_d;
  end

  assign gate_on     = gate_q;
  assign restart_req = lk_q[LK_AR];

  assert_turn_on_R1: assert property (@(posedge clk) disable iff (rst)
    turn_on |=> gate_on);
  assert_no_midcycle_rise_R2: assert property (@(posedge clk) disable iff (rst)
    (!cyc_start && !gate_on) |=> !gate_on);
  assert_ilim_cut_R3: assert property (@(posedge clk) disable iff (rst)
    (gate_on && ilim && !blanking && !cyc_start) |=> !gate_on);
  assert_blank_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (gate_on && blanking && duty_win && !cyc_start && allow_n) |=> gate_on);
  assert_duty_cut_R5: assert property (@(posedge clk) disable iff (rst)
    (!duty_win && !cyc_start) |=> !gate_on);
  assert_fault_gate_off_R6: assert property (@(posedge clk) disable iff (rst)
    restart_req |-> !gate_on);
  assert_fault_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (restart_req && !ar_clear) |=> restart_req);
  assert_uv_cut_R7: assert property (@(posedge clk) disable iff (rst)
    uv_low |=> !gate_on);
  assert_ot_cut_R8: assert property (@(posedge clk) disable iff (rst)
    ot_hot |=> !gate_on);
endmodule

// File: tb/onoff_gate_ctrl_tb.sv
module onoff_gate_ctrl_tb_top;
  localparam int BL = 3;
  localparam int NV = 34;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_start = 0, duty_win = 0, fb_above = 0, fb_sd = 0, ilim = 0;
  logic uv_low = 0, uv_good = 0, ot_hot = 0, ot_cool = 0, ar_clear = 0;
  logic gate_on, restart_req;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  onoff_gate_ctrl #(.BLANK(BL), .SD_CYCLES(2)) dut_i (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .duty_win(duty_win),
    .fb_above(fb_above), .fb_sd(fb_sd), .ilim(ilim), .uv_low(uv_low),
    .uv_good(uv_good), .ot_hot(ot_hot), .ot_cool(ot_cool),
    .ar_clear(ar_clear), .gate_on(gate_on), .restart_req(restart_req)
  );

  // bits: [11]cs [10]fb [9]duty [8]ilim [7]fb_sd [6]uv_low [5]uv_good
  //       [4]ot_hot [3]ot_cool [2]ar_clear | expected [1]gate [0]restart
  localparam logic [11:0] VEC [NV] = '{
    12'b1110_0000_0010, // R1 turn on
    12'b0011_0000_0010, // R2 fb dropped, R4 ilim blanked
    12'b0011_0000_0010, // R4
    12'b0011_0000_0010, // R4 last blanked edge
    12'b0011_0000_0000, // R3 ilim cuts
    12'b0110_0000_0000, // R3 stays off in cycle
    12'b1010_0000_0000, // R2 fb low at start: skip
    12'b0110_0000_0000, // R2 late fb ignored
    12'b1110_0000_0010, // R1
    12'b0000_0000_0000, // R5 window ends
    12'b0010_0000_0000, // R5
    12'b1100_0000_0000, // R5 start with window closed
    12'b1110_0000_0010, // R6 cycle a
    12'b0010_1000_0010, // R6 event
    12'b1110_0000_0010, // R6 count 1
    12'b0010_0000_0010, // R6 no event
    12'b1110_0000_0010, // R6 count reset
    12'b0010_1000_0010, // R6 event
    12'b1110_0000_0010, // R6 count 1
    12'b0010_1000_0010, // R6 event
    12'b1110_0000_0001, // R6 trip
    12'b1110_0000_0001, // R6 held off
    12'b0010_0000_0100, // R6 clear
    12'b1110_0000_0010, // R6 resumes
    12'b0010_1000_0010, // R6 event after clear
    12'b1110_0000_0010, // R6 count 1 only
    12'b0010_0100_0000, // R7 undervoltage
    12'b1110_0000_0000, // R7 locked
    12'b0010_0110_0000, // R7 low wins over good
    12'b0010_0010_0000, // R7 released, no start
    12'b1110_0000_0010, // R7 switches again
    12'b0010_0001_0000, // R8 hot
    12'b1110_0000_0000, // R8 locked
    12'b1110_0000_1010  // R8 release at start
  };
  localparam int TAG [NV] = '{1,2,4,4,3,3,2,2,1,5,5,5,6,6,6,6,6,6,6,6,6,6,6,6,6,6,
                              7,7,7,7,7,8,8,8};

  task automatic apply(input logic [9:0] v);
    cyc_start = v[9]; fb_above = v[8]; duty_win = v[7]; ilim = v[6];
    fb_sd = v[5]; uv_low = v[4]; uv_good = v[3]; ot_hot = v[2];
    ot_cool = v[1]; ar_clear = v[0];
    @(negedge clk);
  endtask

  task automatic check(input int tag, input logic g_exp, input logic r_exp);
    n_chk++;
    if (gate_on !== g_exp || restart_req !== r_exp) begin
      n_fail++;
      $display("FAIL R%0d: gate_on=%b restart_req=%b expected %b %b",
               tag, gate_on, restart_req, g_exp, r_exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R9: watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(9, 1'b0, 1'b0);                 // R9 reset state
    rst = 1'b0;
    apply(10'b1110_0000_00); check(7, 1'b0, 1'b0); // R7 locked after reset
    apply(10'b0010_0010_00); check(7, 1'b0, 1'b0); // R7 release
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][11:2]);
      check(TAG[i], VEC[i][1], VEC[i][0]);
    end
    // R9: reset clears the pending event and the consecutive count
    apply(10'b0010_1000_00); check(9, 1'b1, 1'b0);
    apply(10'b1110_0000_00); check(9, 1'b1, 1'b0);
    apply(10'b0010_1000_00); check(9, 1'b1, 1'b0);
    rst = 1'b1;
    apply(10'b0010_0000_00); check(9, 1'b0, 1'b0);
    rst = 1'b0;
    apply(10'b0010_0010_00); check(9, 1'b0, 1'b0);
    apply(10'b1110_0000_00); check(9, 1'b1, 1'b0);
    apply(10'b0010_0000_00); check(9, 1'b1, 1'b0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule